// File: doc/BRIEF.md
# Hierarchical Carry-Lookahead Adder/Subtractor

This block adds or subtracts two two's-complement operands. A control input selects the operation. The carries come from a tree of radix-4 lookahead units. Each bit forms a generate term (the AND of its effective operand bits) and a propagate term (their XOR). Each unit merges four members into one group generate and one group propagate, and the same unit is reused at every level until a single root remains. The carry-in enters at the root. Each unit then works out the carry into each of its four members from the carry it receives and the terms of its lower-indexed siblings, so carries travel back down the tree to every bit.

For subtraction the second operand is inverted bitwise and the control is fed in as the carry-in, which forms the two's complement. The block reports the carry out of the top bit and a signed overflow flag. The number of tree levels is a parameter, and the width is four raised to that number (64 bits for three levels). Results are captured in output registers that clear on a synchronous active-high reset. A result appears on the outputs one clock edge after its operands are applied.

Top module: `cla_addsub`

## Requirements
- R1: While `rst` is high at a rising clock edge, that edge sets `sum_q` to zero and clears `carry_q` and `ovf_q`.
- R2: With `sub_en` = 0, `sum_q` after the next rising edge equals (`op_a` + `op_b`) mod 2^WIDTH.
- R3: With `sub_en` = 1, `sum_q` after the next rising edge equals (`op_a` - `op_b`) mod 2^WIDTH.
- R4: `carry_q` is the carry out of bit WIDTH-1 after any inversion of `op_b`. When adding, it is 1 exactly when the unsigned sum exceeds 2^WIDTH-1. When subtracting, it is 1 exactly when `op_a` >= `op_b` unsigned (no borrow).
- R5: With `sub_en` = 0, `ovf_q` is 1 exactly when `op_a` and `op_b` have equal sign bits (bit WIDTH-1) and the sign bit of the sum differs from them.
- R6: With `sub_en` = 1, `ovf_q` is 1 exactly when `op_a` and `op_b` have different sign bits and the sign bit of the difference differs from that of `op_a`. This includes `op_b` equal to the most negative value (only bit WIDTH-1 set): the flag is 1 for non-negative `op_a` and 0 for negative `op_a`.
- R7: A carry that travels the whole width through the lookahead tree comes out right. For example, all-ones plus one gives `sum_q` = 0 and `carry_q` = 1, and zero minus one gives all-ones with `carry_q` = 0.
- R8: The parameter LEVELS sets the width to 4^LEVELS. A one-level (4-bit) build meets R2 to R6 for every pair of operands and both operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; results are captured on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| op_a | input | WIDTH | First operand (two's complement or unsigned) |
| op_b | input | WIDTH | Second operand |
| sub_en | input | 1 | 0 selects op_a + op_b, 1 selects op_a - op_b |
| sum_q | output | WIDTH | Registered sum or difference |
| carry_q | output | 1 | Registered carry out of the top bit (no-borrow flag when subtracting) |
| ovf_q | output | 1 | Registered signed overflow flag |

## Verification
The bench pushes operands through the corner values zero, one, all-ones, the largest positive value and the most negative value, in every pairing and for both operations. All-ones plus one forces a carry through every level of the tree. If a group propagate term or a downward carry were wrong, the carry would stop partway and leave a band of wrong sum bits. Subtracting the most negative value finds an overflow flag built from the raw second operand rather than the inverted one, and a carry-in that is not applied would show up as every difference being one too low. A 4-bit build is swept over every operand pair, and thousands of random 64-bit operations catch mistakes in the group equations that the corner values do not reach.

// File: rtl/cla_pkg.sv
package cla_pkg;
  // Members merged by one lookahead unit.
  localparam int RADIX = 4;

  // Number of nodes at tree level lvl (level 0 is the bit level).
  function automatic int level_count(input int levels, input int lvl);
    return RADIX ** (levels - lvl);
  endfunction

  // Position of the first node of level lvl in the flattened node vector.
  function automatic int level_base(input int levels, input int lvl);
    int acc;
    acc = 0;
    for (int i = 0; i < lvl; i++) acc += RADIX ** (levels - i);
    return acc;
  endfunction

  // Node count of all levels, from the bits up to the root.
  function automatic int node_total(input int levels);
    return level_base(levels, levels + 1);
  endfunction
endpackage

// File: rtl/cla_operand_prep.sv
module cla_operand_prep #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             sub_en,
  output logic [WIDTH-1:0] b_eff,
  output logic [WIDTH-1:0] bit_g,
  output logic [WIDTH-1:0] bit_p
);
  // Conditional inversion: XOR against the operation select.
  assign b_eff = op_b ^ {WIDTH{sub_en}};

  // Per-bit generate and propagate (XOR form, reused for the sum).
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign bit_g[i] = op_a[i] & b_eff[i];
    assign bit_p[i] = op_a[i] ^ b_eff[i];
  end
endmodule

// File: rtl/cla_lookahead4.sv
module cla_lookahead4 (
  input  logic [3:0] mem_g,
  input  logic [3:0] mem_p,
  input  logic       grp_cin,
  output logic       grp_g,
  output logic       grp_p,
  output logic [3:0] mem_c
);
  // Upward: merge four members into one group term.
  assign grp_g = mem_g[3]
               | (mem_p[3] & mem_g[2])
               | (mem_p[3] & mem_p[2] & mem_g[1])
               | (mem_p[3] & mem_p[2] & mem_p[1] & mem_g[0]);
  assign grp_p = &mem_p;

  // Downward: carry into each member, two gate levels from grp_cin.
  assign mem_c[0] = grp_cin;
  assign mem_c[1] = mem_g[0] | (mem_p[0] & grp_cin);
  assign mem_c[2] = mem_g[1]
                  | (mem_p[1] & mem_g[0])
                  | (mem_p[1] & mem_p[0] & grp_cin);
  assign mem_c[3] = mem_g[2]
                  | (mem_p[2] & mem_g[1])
                  | (mem_p[2] & mem_p[1] & mem_g[0])
                  | (mem_p[2] & mem_p[1] & mem_p[0] & grp_cin);
endmodule

// File: rtl/cla_tree.sv
module cla_tree
  import cla_pkg::*;
#(
  parameter int LEVELS = 3,
  localparam int WIDTH = RADIX ** LEVELS
) (
  input  logic [WIDTH-1:0] bit_g,
  input  logic [WIDTH-1:0] bit_p,
  input  logic             cin,
  output logic [WIDTH-1:0] bit_cin,
  output logic             root_g,
  output logic             root_p
);
  localparam int NODES = node_total(LEVELS);
  localparam int ROOT  = NODES - 1;

  // Every level packed into one vector; level lv starts at level_base(lv).
  logic [NODES-1:0] node_g;
  logic [NODES-1:0] node_p;
  logic [NODES-1:0] node_c;

  assign node_g[WIDTH-1:0] = bit_g;
  assign node_p[WIDTH-1:0] = bit_p;
  assign node_c[ROOT]      = cin;

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
    localparam int CUR = level_base(LEVELS, lv);
    localparam int UP  = level_base(LEVELS, lv + 1);
    localparam int CNT = level_count(LEVELS, lv + 1);
    for (genvar k = 0; k < CNT; k++) begin : g_grp
      cla_lookahead4 u_grp (
        .mem_g  (node_g[CUR + RADIX*k +: RADIX]),
        .mem_p  (node_p[CUR + RADIX*k +: RADIX]),
        .grp_cin(node_c[UP + k]),
        .grp_g  (node_g[UP + k]),
        .grp_p  (node_p[UP + k]),
        .mem_c  (node_c[CUR + RADIX*k +: RADIX])
      );
    end
  end

  assign bit_cin = node_c[WIDTH-1:0];
  assign root_g  = node_g[ROOT];
  assign root_p  = node_p[ROOT];
endmodule

// File: rtl/cla_addsub.sv
module cla_addsub
  import cla_pkg::*;
#(
  parameter int LEVELS = 3,
  localparam int WIDTH = RADIX ** LEVELS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             sub_en,
  output logic [WIDTH-1:0] sum_q,
  output logic             carry_q,
  output logic             ovf_q
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] bit_g;
  logic [WIDTH-1:0] bit_p;
  logic [WIDTH-1:0] bit_cin;
  logic             root_g;
  logic             root_p;
  logic [WIDTH-1:0] sum_d;
  logic             carry_d;
  logic             ovf_d;

  cla_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .op_a  (op_a),
    .op_b  (op_b),
    .sub_en(sub_en),
    .b_eff (b_eff),
    .bit_g (bit_g),
    .bit_p (bit_p)
  );

  // The operation select doubles as the carry-in at the root.
  cla_tree #(.LEVELS(LEVELS)) u_tree (
    .bit_g  (bit_g),
    .bit_p  (bit_p),
    .cin    (sub_en),
    .bit_cin(bit_cin),
    .root_g (root_g),
    .root_p (root_p)
  );

  assign sum_d   = bit_p ^ bit_cin;
  assign carry_d = root_g | (root_p & sub_en);
  // Same-sign effective operands and a result of the other sign.
  assign ovf_d   = (op_a[MSB] == b_eff[MSB]) & (sum_d[MSB] != op_a[MSB]);

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q   <= '0;
      carry_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      sum_q   <= sum_d;
      carry_q <= carry_d;
      ovf_q   <= ovf_d;
    end
  end

  // Behavioural references used only by the properties below.
  logic [WIDTH-1:0] chk_add;
  logic [WIDTH-1:0] chk_sub;
  assign chk_add = op_a + op_b;
  assign chk_sub = op_a - op_b;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (sum_q == '0 && !carry_q && !ovf_q));

  p_add_sum_r2: assert property (@(posedge clk) disable iff (rst)
    (!rst && !sub_en) |=> sum_q == $past(chk_add));

  p_sub_sum_r3: assert property (@(posedge clk) disable iff (rst)
    (!rst && sub_en) |=> sum_q == $past(chk_sub));

  p_no_borrow_r4: assert property (@(posedge clk) disable iff (rst)
    (!rst && sub_en) |=> carry_q == $past(op_a >= op_b));

  p_add_ovf_r5: assert property (@(posedge clk) disable iff (rst)
    (!rst && !sub_en) |=> ovf_q == $past((op_a[MSB] == op_b[MSB]) && (chk_add[MSB] != op_a[MSB])));

  p_sub_ovf_r6: assert property (@(posedge clk) disable iff (rst)
    (!rst && sub_en) |=> ovf_q == $past((op_a[MSB] != op_b[MSB]) && (chk_sub[MSB] != op_a[MSB])));
endmodule

// File: tb/cla_addsub_tb.sv
module cla_addsub_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] a64 = '0;
  logic [63:0] b64 = '0;
  logic        s64 = 1'b0;
  logic [63:0] sum64;
  logic        cy64;
  logic        ov64;
  logic [3:0]  a4 = '0;
  logic [3:0]  b4 = '0;
  logic        s4 = 1'b0;
  logic [3:0]  sum4;
  logic        cy4;
  logic        ov4;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cla_addsub #(.LEVELS(3)) u_dut (
    .clk(clk), .rst(rst), .op_a(a64), .op_b(b64), .sub_en(s64),
    .sum_q(sum64), .carry_q(cy64), .ovf_q(ov64)
  );

  cla_addsub #(.LEVELS(1)) u_small (
    .clk(clk), .rst(rst), .op_a(a4), .op_b(b4), .sub_en(s4),
    .sum_q(sum4), .carry_q(cy4), .ovf_q(ov4)
  );

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run64(input logic [63:0] a, input logic [63:0] b,
                       input logic s, input string note);
    logic [64:0]        wide;
    logic signed [65:0] exact;
    logic               cy_exp;
    logic               ov_exp;
    @(negedge clk);
    a64 = a; b64 = b; s64 = s;
    wide  = s ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
    exact = s ? ($signed({{2{a[63]}}, a}) - $signed({{2{b[63]}}, b}))
              : ($signed({{2{a[63]}}, a}) + $signed({{2{b[63]}}, b}));
    cy_exp = s ? (a >= b) : wide[64];
    ov_exp = (exact[65:63] != 3'b000) && (exact[65:63] != 3'b111);
    @(negedge clk);
    check(sum64 == wide[63:0], {s ? "R3" : "R2", note}, sum64, wide[63:0]);
    check(cy64 == cy_exp, {"R4", note}, 64'(cy64), 64'(cy_exp));
    check(ov64 == ov_exp, {s ? "R6" : "R5", note}, 64'(ov64), 64'(ov_exp));
  endtask

  initial begin
    logic [63:0] corner [5];
    corner[0] = 64'h0;
    corner[1] = 64'h1;
    corner[2] = '1;
    corner[3] = 64'h7FFF_FFFF_FFFF_FFFF;
    corner[4] = 64'h8000_0000_0000_0000;

    // R1: reset clears registered outputs despite active operands.
    a64 = '1; b64 = 64'h1; a4 = 4'hF; b4 = 4'h1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(sum64 == '0 && !cy64 && !ov64, "R1", {sum64[61:0], cy64, ov64}, 64'h0);
    check(sum4 == '0 && !cy4 && !ov4, "R1", 64'({sum4, cy4, ov4}), 64'h0);
    rst = 1'b0;

    // R7: full-width carry chains, both directions.
    run64('1, 64'h1, 1'b0, " R7");
    check(sum64 == 64'h0 && cy64 == 1'b1, "R7", {sum64[62:0], cy64}, 64'h1);
    run64(64'h0, 64'h1, 1'b1, " R7");
    check(sum64 == '1 && cy64 == 1'b0, "R7", sum64, '1);

    // R6: subtracting the most negative value.
    run64(64'h5, 64'h8000_0000_0000_0000, 1'b1, " R6min");
    check(ov64 == 1'b1, "R6", 64'(ov64), 64'h1);
    run64('1, 64'h8000_0000_0000_0000, 1'b1, " R6min");
    check(ov64 == 1'b0, "R6", 64'(ov64), 64'h0);

    // Corner operand pairings, both operations.
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++)
        for (int s = 0; s < 2; s++)
          run64(corner[i], corner[j], s[0], " corner");

    // Random 64-bit operands.
    for (int n = 0; n < 3000; n++)
      run64({$urandom, $urandom}, {$urandom, $urandom}, n[0], " random");

    // R8: exhaustive sweep of the 4-bit build.
    for (int ai = 0; ai < 16; ai++)
      for (int bi = 0; bi < 16; bi++)
        for (int s = 0; s < 2; s++) begin
          int sa, sb, r, se, ce, oe;
          @(negedge clk);
          a4 = 4'(ai); b4 = 4'(bi); s4 = s[0];
          sa = (ai > 7) ? ai - 16 : ai;
          sb = (bi > 7) ? bi - 16 : bi;
          r  = s ? sa - sb : sa + sb;
          se = (s ? ai - bi : ai + bi) & 15;
          ce = s ? int'(ai >= bi) : int'((ai + bi) > 15);
          oe = int'(r > 7 || r < -8);
          @(negedge clk);
          check(int'(sum4) == se, "R8 sum", 64'(sum4), 64'(se));
          check(int'(cy4) == ce, "R8 carry", 64'(cy4), 64'(ce));
          check(int'(ov4) == oe, "R8 ovf", 64'(ov4), 64'(oe));
        end

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule